// File: doc/BRIEF.md
# Switch-Configured Test Packet Generator

The block produces synthetic detector packets so that a fragment reassembly path can be exercised without any front-end hardware attached. An operator sets an 8-bit switch bank and presses one of four already-debounced push buttons. Each button copies a different split of the switch bank into a configuration register: how many layers to send, how many chains, how many devices per chain, how many memory cells, and how long to pause between packets. The switches have no effect until a button copies them in.

Once started, the generator walks through every layer and, inside each layer, every chain. It emits one packet per (layer, chain) pair on a word-wide fragment stream with a valid/ready handshake. Each packet is cut into fragments of 25 words (100 bytes of 32-bit words), and the last fragment carries whatever is left over. Every payload word holds its layer, its chain and its position within the packet, so a downstream checker can verify each word on its own. A stop request never cuts a packet short.

Top module: `sw_pkt_gen`

## Requirements
- R1: A strobe on `btn_up_i` copies `sw_i[7:0]` into the layer count and, when no run is active and `btn_down_i` is low in the same cycle, starts a run. A run emits layers × chains packets, with the chain index varying fastest, and then ends by itself.
- R2: A strobe on `btn_left_i` copies `sw_i[7:4]` into the chain count and `sw_i[3:0]` into the devices-per-chain count.
- R3: A strobe on `btn_right_i` copies `sw_i[7:4]` into the delay value and `sw_i[3:0]` into the memory-cell count.
- R4: Switch changes that are not strobed in do nothing. Configuration strobed in while a run is active has no effect on that run and applies only from the next start.
- R5: Each packet has devices × cells × 2 words.
- R6: Payload word i of the packet for layer L and chain C is {L[7:0] in bits 31:24, C[3:0] in bits 23:20, i in bits 19:0}.
- R7: `frag_start_o` marks word 0 of each 25-word fragment. `frag_end_o` marks word 24 of a fragment and also the last word of the packet. `pkt_start_o` marks word 0 of the packet and `pkt_end_o` marks its last word.
- R8: Between the last word of one packet and the first word of the next packet in the same run, `frag_valid_o` is low for exactly delay × 256 cycles. A delay of zero gives back-to-back packets.
- R9: A strobe on `btn_down_i` ends the run at a packet boundary. If it arrives mid-packet, that packet is completed and no further packet starts. If it arrives during an inter-packet pause, `gen_on_o` falls within two cycles and nothing more is emitted.
- R10: A start while any of layers, chains, devices or cells is zero emits nothing, and `gen_on_o` stays low.
- R11: While `frag_valid_o` is high and `frag_ready_i` is low, the word and its flags stay unchanged.
- R12: `gen_on_o` is high for the whole of a run. `frag_valid_o` is never high outside a run. After reset both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_up_i | input | 1 | Strobe: latch layers, start |
| btn_down_i | input | 1 | Strobe: stop at packet boundary |
| btn_left_i | input | 1 | Strobe: latch chains and devices |
| btn_right_i | input | 1 | Strobe: latch delay and cells |
| sw_i | input | 8 | Switch bank |
| frag_ready_i | input | 1 | Downstream accepts the current word |
| frag_valid_o | output | 1 | Word available |
| frag_data_o | output | 32 | Payload word |
| pkt_start_o | output | 1 | First word of packet |
| frag_start_o | output | 1 | First word of fragment |
| frag_end_o | output | 1 | Last word of fragment |
| pkt_end_o | output | 1 | Last word of packet |
| gen_on_o | output | 1 | Run active |

## Verification
A word counter stuck or off by one shows at once in the index field of the next word, and it also moves a `frag_end_o` or `pkt_end_o` flag to the wrong word, so the scoreboard flags it on the first word affected. A wrong layer or chain walk shows up at the first packet boundary, either as a wrong index pair or as an extra or missing packet at the end of the run. A pause counter loaded with the wrong value shows up on the first inter-packet gap of a run with a non-zero delay. Stop handling that ignores packet boundaries appears as a truncated packet, or as words left over in the expected queue, when the run ends.

// File: rtl/swpg_pkg.sv
package swpg_pkg;
  typedef struct packed {
    logic [7:0] layers;
    logic [3:0] chains;
    logic [3:0] devs;
    logic [3:0] delay;
    logic [3:0] cells;
  } swpg_cfg_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_SEND = 2'd1,
    S_GAP  = 2'd2
  } swpg_state_e;
endpackage

// File: rtl/swpg_cfg_regs.sv
module swpg_cfg_regs
  import swpg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      up_i,
  input  logic      down_i,
  input  logic      left_i,
  input  logic      right_i,
  input  logic [7:0] sw_i,
  output swpg_cfg_t cfg_o,
  output logic      start_o,
  output logic      stop_o
);
  swpg_cfg_t cfg_q;
  logic      start_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (up_i)    cfg_q.layers <= sw_i;
      if (left_i)  {cfg_q.chains, cfg_q.devs} <= sw_i;
      if (right_i) {cfg_q.delay, cfg_q.cells} <= sw_i;
      // start is delayed one cycle so the sequencer sees the freshly latched value
      start_q <= up_i & ~down_i;
      stop_q  <= down_i;
    end
  end

  assign cfg_o   = cfg_q;
  assign start_o = start_q;
  assign stop_o  = stop_q;
endmodule

// File: rtl/swpg_seq.sv
module swpg_seq
  import swpg_pkg::*;
#(
  parameter int WORDS_PER_CELL = 2,
  parameter int GAP_UNIT       = 256,
  parameter int LEN_W          = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  swpg_cfg_t        cfg_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             pkt_done_i,
  output logic             load_o,
  output logic [LEN_W-1:0] words_o,
  output logic [7:0]       layer_o,
  output logic [3:0]       chain_o,
  output logic             gen_on_o
);
  localparam int GAP_W = $clog2(16 * GAP_UNIT);

  swpg_state_e      state_q;
  swpg_cfg_t        snap_q;
  logic [7:0]       layer_q, nxt_layer;
  logic [3:0]       chain_q, nxt_chain;
  logic [GAP_W-1:0] gap_q;
  logic [LEN_W-1:0] words_q, words_c;
  logic             stop_pend_q, halt, last_pkt, zero_cfg, chain_wrap;

  assign words_c  = LEN_W'(cfg_i.devs) * LEN_W'(cfg_i.cells) * LEN_W'(WORDS_PER_CELL);
  assign zero_cfg = (cfg_i.layers == 8'd0) | (cfg_i.chains == 4'd0) |
                    (cfg_i.devs == 4'd0) | (cfg_i.cells == 4'd0);
  assign halt       = stop_pend_q | stop_i;
  assign chain_wrap = (chain_q == snap_q.chains - 4'd1);
  assign last_pkt   = chain_wrap & (layer_q == snap_q.layers - 8'd1);
  assign nxt_chain  = chain_wrap ? 4'd0 : chain_q + 4'd1;
  assign nxt_layer  = chain_wrap ? layer_q + 8'd1 : layer_q;

  always_comb begin
    load_o  = 1'b0;
    words_o = words_q;
    layer_o = layer_q;
    chain_o = chain_q;
    unique case (state_q)
      S_IDLE: begin
        load_o  = start_i & ~zero_cfg;
        words_o = words_c;
        layer_o = 8'd0;
        chain_o = 4'd0;
      end
      S_SEND: begin
        load_o  = pkt_done_i & ~halt & ~last_pkt & (snap_q.delay == 4'd0);
        layer_o = nxt_layer;
        chain_o = nxt_chain;
      end
      S_GAP:   load_o = (gap_q == '0) & ~halt;
      default: load_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      snap_q      <= '0;
      layer_q     <= '0;
      chain_q     <= '0;
      gap_q       <= '0;
      words_q     <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          stop_pend_q <= 1'b0;
          if (start_i && !zero_cfg) begin
            snap_q  <= cfg_i;
            words_q <= words_c;
            layer_q <= 8'd0;
            chain_q <= 4'd0;
            state_q <= S_SEND;
          end
        end
        S_SEND: begin
          if (stop_i) stop_pend_q <= 1'b1;
          if (pkt_done_i) begin
            if (halt || last_pkt) begin
              state_q <= S_IDLE;
            end else begin
              layer_q <= nxt_layer;
              chain_q <= nxt_chain;
              if (snap_q.delay != 4'd0) begin
                gap_q   <= GAP_W'(snap_q.delay) * GAP_W'(GAP_UNIT) - GAP_W'(1);
                state_q <= S_GAP;
              end
            end
          end
        end
        S_GAP: begin
          if (halt)               state_q <= S_IDLE;
          else if (gap_q == '0)   state_q <= S_SEND;
          else                    gap_q   <= gap_q - GAP_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign gen_on_o = (state_q != S_IDLE);
endmodule

// File: rtl/swpg_frag.sv
module swpg_frag #(
  parameter int WORD_W     = 32,
  parameter int LEN_W      = 9,
  parameter int FRAG_WORDS = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LEN_W-1:0]  words_i,
  input  logic [7:0]        layer_i,
  input  logic [3:0]        chain_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o,
  output logic              pkt_start_o,
  output logic              frag_start_o,
  output logic              frag_end_o,
  output logic              pkt_end_o,
  output logic              done_o
);
  localparam int IDX_W = WORD_W - 12;
  localparam int FP_W  = $clog2(FRAG_WORDS);

  logic             active_q;
  logic [LEN_W-1:0] idx_q, len_q;
  logic [FP_W-1:0]  fpos_q;
  logic [7:0]       layer_q;
  logic [3:0]       chain_q;
  logic             last_word, frag_tail, hs;

  assign last_word = (idx_q == len_q - LEN_W'(1));
  assign frag_tail = (fpos_q == FP_W'(FRAG_WORDS - 1));
  assign hs        = active_q & ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
      fpos_q   <= '0;
      layer_q  <= '0;
      chain_q  <= '0;
    end else if (load_i) begin
      // load wins over completion so back-to-back packets leave no bubble
      active_q <= 1'b1;
      idx_q    <= '0;
      fpos_q   <= '0;
      len_q    <= words_i;
      layer_q  <= layer_i;
      chain_q  <= chain_i;
    end else if (hs) begin
      if (last_word) active_q <= 1'b0;
      idx_q  <= idx_q + LEN_W'(1);
      fpos_q <= (frag_tail || last_word) ? '0 : fpos_q + FP_W'(1);
    end
  end

  assign valid_o      = active_q;
  assign data_o       = {layer_q, chain_q, IDX_W'(idx_q)};
  assign pkt_start_o  = (idx_q == '0);
  assign frag_start_o = (fpos_q == '0);
  assign frag_end_o   = frag_tail | last_word;
  assign pkt_end_o    = last_word;
  assign done_o       = hs & last_word;
endmodule

// File: rtl/sw_pkt_gen.sv
module sw_pkt_gen
  import swpg_pkg::*;
#(
  parameter int WORD_W         = 32,
  parameter int WORDS_PER_CELL = 2,
  parameter int FRAG_WORDS     = 25,
  parameter int GAP_UNIT       = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              btn_up_i,
  input  logic              btn_down_i,
  input  logic              btn_left_i,
  input  logic              btn_right_i,
  input  logic [7:0]        sw_i,
  input  logic              frag_ready_i,
  output logic              frag_valid_o,
  output logic [WORD_W-1:0] frag_data_o,
  output logic              pkt_start_o,
  output logic              frag_start_o,
  output logic              frag_end_o,
  output logic              pkt_end_o,
  output logic              gen_on_o
);
  localparam int LEN_W = $clog2(15 * 15 * WORDS_PER_CELL + 1);

  swpg_cfg_t        cfg;
  logic             start, stop, load, done;
  logic [LEN_W-1:0] words;
  logic [7:0]       layer;
  logic [3:0]       chain;

  swpg_cfg_regs u_cfg (
    .clk_i, .rst_ni,
    .up_i(btn_up_i), .down_i(btn_down_i), .left_i(btn_left_i), .right_i(btn_right_i),
    .sw_i, .cfg_o(cfg), .start_o(start), .stop_o(stop)
  );

  swpg_seq #(.WORDS_PER_CELL(WORDS_PER_CELL), .GAP_UNIT(GAP_UNIT), .LEN_W(LEN_W)) u_seq (
    .clk_i, .rst_ni, .cfg_i(cfg), .start_i(start), .stop_i(stop), .pkt_done_i(done),
    .load_o(load), .words_o(words), .layer_o(layer), .chain_o(chain), .gen_on_o
  );

  swpg_frag #(.WORD_W(WORD_W), .LEN_W(LEN_W), .FRAG_WORDS(FRAG_WORDS)) u_frag (
    .clk_i, .rst_ni, .load_i(load), .words_i(words), .layer_i(layer), .chain_i(chain),
    .ready_i(frag_ready_i), .valid_o(frag_valid_o), .data_o(frag_data_o),
    .pkt_start_o, .frag_start_o, .frag_end_o, .pkt_end_o, .done_o(done)
  );
endmodule

// File: rtl/swpg_chk.sv
module swpg_chk #(
  parameter int WORD_W     = 32,
  parameter int FRAG_WORDS = 25
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid,
  input logic              ready,
  input logic [WORD_W-1:0] data,
  input logic              frag_start,
  input logic              frag_end,
  input logic              pkt_end,
  input logic              gen_on
);
  localparam int CW = $clog2(FRAG_WORDS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (valid && ready) cnt_q <= frag_end ? '0 : cnt_q + CW'(1);
  end

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && !ready |=> valid && $stable(data) && $stable(pkt_end) && $stable(frag_end));
  p_pkt_end_frag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && pkt_end |-> frag_end);
  p_frag_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid && (cnt_q == CW'(FRAG_WORDS - 1)) |-> frag_end);
  p_frag_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> (frag_start == (cnt_q == '0)));
  p_boundary_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gen_on) |-> $past(!valid || (ready && pkt_end)));
  p_valid_in_run_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> gen_on);
endmodule

bind sw_pkt_gen swpg_chk #(.WORD_W(WORD_W), .FRAG_WORDS(FRAG_WORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid(frag_valid_o), .ready(frag_ready_i),
  .data(frag_data_o), .frag_start(frag_start_o), .frag_end(frag_end_o),
  .pkt_end(pkt_end_o), .gen_on(gen_on_o)
);

// File: tb/sw_pkt_gen_tb.sv
`timescale 1ns/1ps
module sw_pkt_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  btn = '0;   // 0 up, 1 down, 2 left, 3 right
  logic [7:0]  sw = '0;
  logic        ready = 1'b1;
  logic        valid, pkt_start, frag_start, frag_end, pkt_end, gen_on;
  logic [31:0] data;

  int n_chk = 0, n_fail = 0, rx_words = 0, exp_gap = 0;
  bit throttle = 1'b0, done_flag = 1'b0;
  logic [35:0] exp_q[$];

  always #2.5 clk = ~clk;

  sw_pkt_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .btn_up_i(btn[0]), .btn_down_i(btn[1]),
    .btn_left_i(btn[2]), .btn_right_i(btn[3]), .sw_i(sw), .frag_ready_i(ready),
    .frag_valid_o(valid), .frag_data_o(data), .pkt_start_o(pkt_start),
    .frag_start_o(frag_start), .frag_end_o(frag_end), .pkt_end_o(pkt_end), .gen_on_o(gen_on)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic push_pkt(input int layer, input int chain, input int len);
    for (int i = 0; i < len; i++) begin
      logic [3:0] fl;
      fl = {i == 0, (i % 25) == 0, ((i % 25) == 24) || (i == len - 1), i == len - 1};
      exp_q.push_back({fl, layer[7:0], chain[3:0], i[19:0]});
    end
  endtask

  task automatic push_run(input int layers, input int chains, input int devs, input int cells);
    for (int l = 0; l < layers; l++)
      for (int c = 0; c < chains; c++) push_pkt(l, c, devs * cells * 2);
  endtask

  task automatic press(input int which, input logic [7:0] v);
    @(posedge clk); #1;
    sw = v; btn[which] = 1'b1;
    @(posedge clk); #1;
    btn = '0;
  endtask

  task automatic wait_idle();
    repeat (3) @(posedge clk);
    while (gen_on) @(posedge clk);
    @(negedge clk);
  endtask

  // ready pattern
  initial begin
    logic [7:0] lfsr = 8'h5a;
    forever begin
      @(posedge clk); #1;
      ready = throttle ? lfsr[0] : 1'b1;
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  end

  // monitor: scoreboard pop, hold check, gap check
  initial begin
    bit after_eop = 1'b0, held = 1'b0;
    int gap = 0;
    logic [35:0] held_w;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held) begin
          chk("R11 hold", {valid, pkt_start, frag_start, frag_end, pkt_end, data},
              {1'b1, held_w});
          held = 1'b0;
        end
        if (valid && !ready) begin
          held = 1'b1;
          held_w = {pkt_start, frag_start, frag_end, pkt_end, data};
        end
        if (!gen_on) after_eop = 1'b0;
        if (after_eop && valid) begin
          chk("R8 gap", gap, exp_gap);
          after_eop = 1'b0;
        end
        if (valid && ready) begin
          rx_words++;
          if (exp_q.size() == 0) begin
            chk("R1 R9 unexpected word", {pkt_start, frag_start, frag_end, pkt_end, data}, 64'hdead);
          end else begin
            chk("R5 R6 R7 word", {pkt_start, frag_start, frag_end, pkt_end, data}, exp_q.pop_front());
          end
          if (pkt_end) begin
            after_eop = 1'b1;
            gap = 0;
          end
        end else if (after_eop && !valid) begin
          gap++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R12 reset valid", valid, 0);
    chk("R12 reset gen_on", gen_on, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1 R2 R3 R5 R8: 2 layers x 2 chains, 3 devs x 1 cell, back-to-back
    press(2, 8'h23);
    press(3, 8'h01);
    exp_gap = 0;
    push_run(2, 2, 3, 1);
    press(0, 8'd2);
    wait_idle();
    chk("R1 run drained", exp_q.size(), 0);
    chk("R12 gen_on low after run", gen_on, 0);

    // R7 R11: 120-word packet split into 25-word fragments, throttled
    throttle = 1'b1;
    press(2, 8'h1f);
    press(3, 8'h04);
    push_run(1, 1, 15, 4);
    press(0, 8'd1);
    wait_idle();
    chk("R7 fragments drained", exp_q.size(), 0);
    throttle = 1'b0;

    // R8: delay 1 -> 256 idle cycles between packets
    press(2, 8'h21);
    press(3, 8'h11);
    exp_gap = 256;
    push_run(1, 2, 1, 1);
    press(0, 8'd1);
    wait_idle();
    chk("R8 delayed run drained", exp_q.size(), 0);

    // R4: unstrobed switches ignored; mid-run latch applies only to next run
    press(2, 8'h1f);
    press(3, 8'h0f);
    exp_gap = 0;
    @(posedge clk); #1 sw = 8'h77;
    repeat (5) @(posedge clk);
    throttle = 1'b1;
    push_run(1, 1, 15, 15);
    press(0, 8'd1);
    repeat (20) @(posedge clk);
    press(2, 8'h31);
    press(3, 8'h01);
    wait_idle();
    chk("R4 run unaffected by mid-run latch", exp_q.size(), 0);
    throttle = 1'b0;
    push_run(1, 3, 1, 1);
    press(0, 8'd1);
    wait_idle();
    chk("R4 new config applied on next run", exp_q.size(), 0);

    // R9: stop mid-packet completes current packet only
    throttle = 1'b1;
    press(2, 8'h2f);
    press(3, 8'h04);
    base = rx_words;
    push_pkt(0, 0, 120);
    press(0, 8'd3);
    while (rx_words < base + 10) @(posedge clk);
    press(1, 8'h00);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 stop mid-packet words", rx_words - base, 120);
    chk("R9 stop mid-packet gen_on", gen_on, 0);
    throttle = 1'b0;

    // R9: stop during pause ends the run at once
    press(2, 8'h21);
    press(3, 8'h21);
    base = rx_words;
    push_pkt(0, 0, 2);
    press(0, 8'd1);
    while (rx_words < base + 2) @(posedge clk);
    repeat (10) @(posedge clk);
    press(1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R9 stop in gap gen_on", gen_on, 0);
    repeat (600) @(negedge clk);
    chk("R9 stop in gap words", rx_words - base, 2);

    // R10: zero cells -> nothing
    press(3, 8'h00);
    base = rx_words;
    press(0, 8'd4);
    repeat (3) @(negedge clk);
    chk("R10 zero cfg gen_on", gen_on, 0);
    repeat (30) @(negedge clk);
    chk("R10 zero cfg words", rx_words - base, 0);
    chk("R10 zero cfg valid", valid, 0);

    done_flag = 1'b1;
    finish_run();
  end
endmodule